// File: doc/BRIEF.md
# Per-Load Stride Prefetch Table

This block watches the stream of executed loads and learns, separately for each load instruction, whether its effective addresses advance by a constant step. Each load carries its program counter and effective address on a one-cycle valid strobe. The low program-counter bits above the instruction alignment select one slot of a direct-mapped table. The remaining upper bits are kept in the slot as a tag. The slot also keeps the last address seen, the last observed step and a two-bit confidence state. A load whose stride is confirmed starts a burst of prefetch requests. The burst leaves through a valid/ready port as the current address plus one, two and up to a configurable number of strides.

Confidence follows four named states. A newly claimed slot starts in `CONF_INIT`. `CONF_TRANS` means one step has been seen that did not confirm. `CONF_STEADY` means the step repeated. `CONF_NOPRED` means the stream looks irregular. A second small machine drives the request port. It rests in `ISS_IDLE`, and it stays in `ISS_SEND` while requests of the current burst remain. A fresh confirmed load restarts the burst. Requests of the older burst that were not yet taken are dropped.

Top module: `stride_prefetch_table`

## Requirements
- R1: After reset the request port is idle (`pf_valid` low) and every table slot is empty, so the first load of any PC raises no request.
- R2: The slot index is `ld_pc[5:2]` (bits above the ALIGN_BITS=2 alignment bits, ENTRIES=16). The tag is `ld_pc[31:6]`. A load that finds an empty slot or a different tag claims the slot: the tag and last address are taken from the load, the step becomes zero, the state becomes `CONF_INIT`, and no request is raised.
- R3: On a tag hit the observed step is the load address minus the stored last address, modulo 2^32 (so negative steps wrap). The stored last address always becomes the load address, and the stored step becomes the observed step.
- R4: On a tag hit the confidence moves as follows. A "match" means the observed step equals the stored step. `CONF_INIT` goes to `CONF_STEADY` on a match and to `CONF_TRANS` otherwise. `CONF_TRANS` goes to `CONF_STEADY` on a match and to `CONF_NOPRED` otherwise. `CONF_STEADY` stays on a match and returns to `CONF_INIT` otherwise. `CONF_NOPRED` goes to `CONF_TRANS` on a match and stays otherwise.
- R5: A burst is launched only by a hit whose new state is `CONF_STEADY` and whose observed step is non-zero. A repeated address never prefetches, and a fresh stream first prefetches on its third load.
- R6: One cycle after a launching load, `pf_valid` is high with `pf_addr` equal to address + step. Each accepted request (`pf_valid && pf_ready`) advances `pf_addr` by one more step, up to address + DEGREE×step (DEGREE=4).
- R7: While `pf_valid` is high and `pf_ready` low, `pf_addr` and `pf_valid` hold, unless a new burst is launched in that cycle.
- R8: A launching load replaces any unfinished burst. The next request shown is the new burst's first address.
- R9: Loads whose PCs map to different slots keep independent strides and states, even when their accesses interleave cycle by cycle.
- R10: After the DEGREE-th request of a burst is accepted, `pf_valid` is low until the next launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | A load executes this cycle |
| ld_pc | input | 32 | Program counter of the load |
| ld_addr | input | 32 | Effective address of the load |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | The request is taken this cycle |
| pf_addr | output | 32 | Prefetch address |

## Verification
The bench builds the block with its defaults: 16 slots, two alignment bits and a burst of four. With 16 slots, a handful of PCs such as 0x200 and 0x240 share a slot with different tags, so replacement in the middle of a stream can be reached with short random runs. The burst of four is longer than a stream's load spacing in the random phase. Launches therefore regularly land on an unfinished burst while `pf_ready` is randomly withheld, which brings the overwrite and hold rules into play together. Steps are drawn from a small set that includes zero and negative values, so every confidence transition and the wrap of negative strides recur many times.

// File: rtl/spt_pkg.sv
package spt_pkg;

    // Confidence of a table slot in its recorded stride.
    typedef enum logic [1:0] {
        CONF_INIT   = 2'd0,
        CONF_TRANS  = 2'd1,
        CONF_STEADY = 2'd2,
        CONF_NOPRED = 2'd3
    } conf_e;

    // Request port sequencer.
    typedef enum logic {
        ISS_IDLE = 1'b0,
        ISS_SEND = 1'b1
    } iss_e;

endpackage

// File: rtl/spt_table.sv
module spt_table
    import spt_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 26,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [ADDR_W-1:0] rd_prev,
    output logic [ADDR_W-1:0] rd_stride,
    output conf_e             rd_state,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_prev,
    input  logic [ADDR_W-1:0] wr_stride,
    input  conf_e             wr_state
);

    logic              v_all   [ENTRIES];
    logic [TAG_W-1:0]  tag_all [ENTRIES];
    logic [ADDR_W-1:0] prv_all [ENTRIES];
    logic [ADDR_W-1:0] str_all [ENTRIES];
    conf_e             st_all  [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        logic              v_q;
        logic [TAG_W-1:0]  tag_q;
        logic [ADDR_W-1:0] prv_q;
        logic [ADDR_W-1:0] str_q;
        conf_e             st_q;
        logic              sel;

        assign sel = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q   <= 1'b0;
                tag_q <= '0;
                prv_q <= '0;
                str_q <= '0;
                st_q  <= CONF_INIT;
            end else if (sel) begin
                v_q   <= 1'b1;
                tag_q <= wr_tag;
                prv_q <= wr_prev;
                str_q <= wr_stride;
                st_q  <= wr_state;
            end
        end

        assign v_all[e]   = v_q;
        assign tag_all[e] = tag_q;
        assign prv_all[e] = prv_q;
        assign str_all[e] = str_q;
        assign st_all[e]  = st_q;
    end

    assign rd_valid  = v_all[rd_idx];
    assign rd_tag    = tag_all[rd_idx];
    assign rd_prev   = prv_all[rd_idx];
    assign rd_stride = str_all[rd_idx];
    assign rd_state  = st_all[rd_idx];

    // R2: a slot written this cycle reads back as occupied in the next one.
    p_claim_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_idx == wr_idx) |=> (rd_idx != $past(wr_idx)) || rd_valid)
        else $error("p_claim_r2");

endmodule

// File: rtl/spt_update.sv
module spt_update
    import spt_pkg::*;
#(
    parameter int TAG_W  = 26,
    parameter int ADDR_W = 32
) (
    input  logic              ld_valid,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              rd_valid,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [ADDR_W-1:0] rd_prev,
    input  logic [ADDR_W-1:0] rd_stride,
    input  conf_e             rd_state,
    output logic              hit,
    output logic [ADDR_W-1:0] wr_stride,
    output conf_e             wr_state,
    output logic              launch
);

    logic [ADDR_W-1:0] obs_stride;
    logic              same_step;

    assign hit        = rd_valid && (rd_tag == ld_tag);
    assign obs_stride = ld_addr - rd_prev;
    assign same_step  = (obs_stride == rd_stride);

    // Confidence transition for the addressed slot.
    always_comb begin
        wr_state  = CONF_INIT;
        wr_stride = '0;
        if (hit) begin
            wr_stride = obs_stride;
            unique case (rd_state)
                CONF_INIT:   wr_state = same_step ? CONF_STEADY : CONF_TRANS;
                CONF_TRANS:  wr_state = same_step ? CONF_STEADY : CONF_NOPRED;
                CONF_STEADY: wr_state = same_step ? CONF_STEADY : CONF_INIT;
                CONF_NOPRED: wr_state = same_step ? CONF_TRANS  : CONF_NOPRED;
                default:     wr_state = CONF_INIT;
            endcase
        end
    end

    assign launch = ld_valid && hit && (wr_state == CONF_STEADY) && (obs_stride != '0);

endmodule

// File: rtl/spt_issue.sv
module spt_issue
    import spt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEGREE = 4,
    localparam int CNT_W = $clog2(DEGREE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] step,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr
);

    iss_e              st_q, st_d;
    logic [ADDR_W-1:0] nxt_q;
    logic [ADDR_W-1:0] step_q;
    logic [CNT_W-1:0]  left_q;
    logic              take;

    assign take = (st_q == ISS_SEND) && pf_ready;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ISS_IDLE;
        else        st_q <= st_d;
    end

    // Next state.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ISS_IDLE: if (launch) st_d = ISS_SEND;
            ISS_SEND: begin
                if (launch)                              st_d = ISS_SEND;
                else if (take && left_q == CNT_W'(1))    st_d = ISS_IDLE;
            end
            default:  st_d = ISS_IDLE;
        endcase
    end

    // Burst address and remaining count.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nxt_q  <= '0;
            step_q <= '0;
            left_q <= '0;
        end else if (launch) begin
            nxt_q  <= base_addr + step;
            step_q <= step;
            left_q <= CNT_W'(DEGREE);
        end else if (take) begin
            nxt_q  <= nxt_q + step_q;
            left_q <= left_q - CNT_W'(1);
        end
    end

    // Outputs.
    always_comb begin
        pf_valid = (st_q == ISS_SEND);
        pf_addr  = nxt_q;
    end

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready && !launch) |=> (pf_valid && $stable(pf_addr)))
        else $error("p_hold_r7");

    p_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && pf_ready && !launch && left_q == CNT_W'(1)) |=> !pf_valid)
        else $error("p_drain_r10");

    p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && pf_ready && !launch && left_q > CNT_W'(1))
            |=> (pf_valid && pf_addr == $past(pf_addr) + step_q))
        else $error("p_advance_r6");

endmodule

// File: rtl/stride_prefetch_table.sv
module stride_prefetch_table
    import spt_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int ADDR_W     = 32,
    parameter int ENTRIES    = 16,
    parameter int ALIGN_BITS = 2,
    parameter int DEGREE     = 4,
    localparam int IDX_W     = $clog2(ENTRIES),
    localparam int TAG_LO    = ALIGN_BITS + IDX_W,
    localparam int TAG_W     = PC_W - TAG_LO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [PC_W-1:0]   ld_pc,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr
);

    logic [IDX_W-1:0]  slot;
    logic [TAG_W-1:0]  ltag;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [ADDR_W-1:0] rd_prev;
    logic [ADDR_W-1:0] rd_stride;
    conf_e             rd_state;
    logic              hit;
    logic [ADDR_W-1:0] wr_stride;
    conf_e             wr_state;
    logic              launch;

    assign slot = ld_pc[TAG_LO-1:ALIGN_BITS];
    assign ltag = ld_pc[PC_W-1:TAG_LO];

    spt_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (slot),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_prev   (rd_prev),
        .rd_stride (rd_stride),
        .rd_state  (rd_state),
        .wr_en     (ld_valid),
        .wr_idx    (slot),
        .wr_tag    (ltag),
        .wr_prev   (ld_addr),
        .wr_stride (wr_stride),
        .wr_state  (wr_state)
    );

    spt_update #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_update (
        .ld_valid  (ld_valid),
        .ld_tag    (ltag),
        .ld_addr   (ld_addr),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_prev   (rd_prev),
        .rd_stride (rd_stride),
        .rd_state  (rd_state),
        .hit       (hit),
        .wr_stride (wr_stride),
        .wr_state  (wr_state),
        .launch    (launch)
    );

    spt_issue #(.ADDR_W(ADDR_W), .DEGREE(DEGREE)) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .base_addr (ld_addr),
        .step      (wr_stride),
        .pf_valid  (pf_valid),
        .pf_ready  (pf_ready),
        .pf_addr   (pf_addr)
    );

    p_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (pf_valid && pf_addr == $past(ld_addr) + $past(wr_stride)))
        else $error("p_launch_r6");

    p_miss_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !hit) |-> !launch)
        else $error("p_miss_quiet_r5");

    p_zero_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && hit && ld_addr == rd_prev) |-> !launch)
        else $error("p_zero_step_r5");

endmodule

// File: tb/stride_prefetch_table_test.sv
`timescale 1ns/1ps
module stride_prefetch_table_test;

    localparam int DEG = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_pc = '0;
    logic [31:0] ld_addr = '0;
    logic        pf_valid;
    logic        pf_ready = 1'b0;
    logic [31:0] pf_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    stride_prefetch_table uut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_pc(ld_pc),
        .ld_addr(ld_addr), .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
    );

    // Reference model built from the requirements.
    bit          m_v   [16];
    logic [25:0] m_tag [16];
    logic [31:0] m_prv [16];
    logic [31:0] m_str [16];
    int          m_st  [16];   // 0 init, 1 transient, 2 steady, 3 no-prediction
    bit          m_busy = 1'b0;
    logic [31:0] m_addr = '0;
    logic [31:0] m_step = '0;
    int          m_left = 0;

    function automatic int next_conf(int cur, bit match);
        case (cur)
            0:       return match ? 2 : 1;
            1:       return match ? 2 : 3;
            2:       return match ? 2 : 0;
            default: return match ? 1 : 3;
        endcase
    endfunction

    function automatic void model_load(logic [31:0] pc, logic [31:0] a);
        int          i;
        logic [31:0] obs;
        int          ns;
        i = int'(pc[5:2]);
        if (!m_v[i] || m_tag[i] != pc[31:6]) begin
            m_v[i] = 1'b1; m_tag[i] = pc[31:6]; m_prv[i] = a; m_str[i] = '0; m_st[i] = 0;
            return;
        end
        obs = a - m_prv[i];
        ns  = next_conf(m_st[i], obs == m_str[i]);
        m_prv[i] = a; m_str[i] = obs; m_st[i] = ns;
        if (ns == 2 && obs != 0) begin
            m_busy = 1'b1; m_addr = a + obs; m_step = obs; m_left = DEG;
        end
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One cycle: compare outputs, then drive inputs and advance the model.
    task automatic step(input bit v, input logic [31:0] pc, input logic [31:0] a,
                        input bit rdy, input string req);
        @(negedge clk);
        check(pf_valid == m_busy, req, "pf_valid", {31'b0, pf_valid}, {31'b0, m_busy});
        if (m_busy) check(pf_addr == m_addr, req, "pf_addr", pf_addr, m_addr);
        ld_valid = v; ld_pc = pc; ld_addr = a; pf_ready = rdy;
        if (m_busy && rdy) begin
            m_left--; m_addr = m_addr + m_step;
            if (m_left == 0) m_busy = 1'b0;
        end
        if (v) model_load(pc, a);
    endtask

    task automatic idle(input int n, input bit rdy, input string req);
        for (int k = 0; k < n; k++) step(1'b0, 32'h0, 32'h0, rdy, req);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    logic [31:0] pool_pc  [6];
    logic [31:0] pool_a   [6];
    logic [31:0] pool_s   [6];
    logic [31:0] steps    [6];

    initial begin
        int seed;
        seed = $urandom(32'h5eed_1234);
        for (int i = 0; i < 16; i++) begin m_v[i] = 0; m_tag[i] = 0; m_prv[i] = 0; m_str[i] = 0; m_st[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset, first load of a PC is silent
        idle(2, 1'b1, "R1");
        step(1'b1, 32'h100, 32'h1000, 1'b1, "R1");
        idle(1, 1'b1, "R1");

        // R5 / R6 / R10: stream 0x1000, 0x1040, 0x1080 launches on third load
        step(1'b1, 32'h100, 32'h1040, 1'b1, "R5");
        step(1'b1, 32'h100, 32'h1080, 1'b1, "R5");
        idle(5, 1'b1, "R6");
        idle(3, 1'b1, "R10");

        // R7: back-pressure holds the offered address
        step(1'b1, 32'h100, 32'h10C0, 1'b0, "R7");
        idle(4, 1'b0, "R7");
        idle(6, 1'b1, "R7");

        // R8: new launch replaces an unfinished burst
        step(1'b1, 32'h100, 32'h1100, 1'b1, "R8");
        step(1'b0, 32'h0, 32'h0, 1'b1, "R8");
        step(1'b1, 32'h100, 32'h1140, 1'b1, "R8");
        idle(6, 1'b1, "R8");

        // R5: repeated address never prefetches
        for (int k = 0; k < 5; k++) step(1'b1, 32'h10C, 32'h3000, 1'b1, "R5");
        idle(2, 1'b1, "R5");

        // R2: 0x200 and 0x240 share slot 0 with different tags
        step(1'b1, 32'h200, 32'h5000, 1'b1, "R2");
        step(1'b1, 32'h200, 32'h5010, 1'b1, "R2");
        step(1'b1, 32'h240, 32'h5020, 1'b1, "R2");
        step(1'b1, 32'h200, 32'h5030, 1'b1, "R2");
        step(1'b1, 32'h200, 32'h5040, 1'b1, "R2");
        idle(2, 1'b1, "R2");
        step(1'b1, 32'h200, 32'h5050, 1'b1, "R2");
        idle(6, 1'b1, "R2");

        // R3: negative step wraps modulo 2^32
        step(1'b1, 32'h114, 32'h10, 1'b1, "R3");
        step(1'b1, 32'h114, 32'h08, 1'b1, "R3");
        step(1'b1, 32'h114, 32'h00, 1'b1, "R3");
        idle(6, 1'b1, "R3");

        // R4: transient -> no-prediction -> transient -> steady, steady -> init
        step(1'b1, 32'h118, 32'h100, 1'b1, "R4");
        step(1'b1, 32'h118, 32'h108, 1'b1, "R4");
        step(1'b1, 32'h118, 32'h118, 1'b1, "R4");
        step(1'b1, 32'h118, 32'h130, 1'b1, "R4");
        step(1'b1, 32'h118, 32'h148, 1'b1, "R4");
        step(1'b1, 32'h118, 32'h160, 1'b1, "R4");
        idle(5, 1'b1, "R4");
        step(1'b1, 32'h118, 32'h200, 1'b1, "R4");
        step(1'b1, 32'h118, 32'h2A0, 1'b1, "R4");
        idle(5, 1'b1, "R4");

        // R9: two slots interleaved cycle by cycle
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 32'h124, 32'h8000 + 32'(k * 32'h40), 1'b1, "R9");
            step(1'b1, 32'h128, 32'h9000 - 32'(k * 32'h20), 1'b1, "R9");
        end
        idle(8, 1'b1, "R9");

        // Random phase: PCs collide in slots 0 and 1
        pool_pc[0] = 32'h200; pool_pc[1] = 32'h240; pool_pc[2] = 32'h204;
        pool_pc[3] = 32'h284; pool_pc[4] = 32'h30C; pool_pc[5] = 32'h410;
        steps[0] = 32'h0; steps[1] = 32'h40; steps[2] = 32'hFFFF_FFC0;
        steps[3] = 32'h8; steps[4] = 32'h100; steps[5] = 32'h4;
        for (int i = 0; i < 6; i++) begin
            pool_a[i] = 32'h1_0000 * 32'(i + 1);
            pool_s[i] = steps[$urandom % 6];
        end
        for (int n = 0; n < 4000; n++) begin
            int  p;
            bit  v;
            bit  r;
            p = $urandom % 6;
            v = ($urandom % 100) < 55;
            r = ($urandom % 100) < 65;
            if (($urandom % 100) < 8) pool_s[p] = steps[$urandom % 6];
            if (v) pool_a[p] = pool_a[p] + pool_s[p];
            step(v, pool_pc[p], pool_a[p], r, "R4");
        end
        idle(10, 1'b1, "R10");

        summary();
        $finish;
    end

endmodule